// File: doc/BRIEF.md
# Pointer-Register I2C Target

This block is the serial front end of a small register-mapped I/O device. It runs on a fast system clock and oversamples the two bus lines. Each line passes through a two-flop synchronizer and a stable-count filter, which removes short spikes. From the cleaned levels the block finds Start, repeated Start and Stop conditions and the SCL edges. It accepts a 7-bit target address made of a fixed upper field and two strap inputs. It pulls SDA low through an open-drain enable, so `sda_oe` high means the line is driven low.

In a write transfer the first byte after the address is a command byte. Its low bits load a register pointer. Every later byte of the transfer is handed to the register bank as a one-cycle write strobe, carrying the pointer and the data. In a read transfer the block asks the bank for one byte per data phase. It shifts the byte out MSB first, until the master leaves the acknowledge bit high. The pointer is held across transactions and never advances. Any number of reads or writes therefore reach the same register until a new command byte arrives.

Top module: `i2c_ptr_target`

## Requirements
- R1: After a synchronous reset `sda_oe`, `wr_stb`, `rd_req`, `ack_stb` and `nack_stb` are low, and the pointer is 0. A read issued before any command byte therefore fetches register 0 (`rd_ptr` = 0).
- R2: An address byte whose upper seven bits, sent MSB first, equal binary 11100 followed by `strap[1]` and `strap[0]` is acknowledged: SDA is held low for the whole ninth clock. Bit 0 of the address byte selects the direction, with 1 meaning read and 0 meaning write.
- R3: An address byte with any other value gets no acknowledge, and the block leaves SDA released for the rest of the transfer. Until the next Start or Stop it raises no `wr_stb`, `rd_req`, `ack_stb` or `nack_stb`, and the pointer is unchanged.
- R4: In a write transfer the byte after the address is the command byte. It is acknowledged, and only its two low bits load the pointer: 0 is input, 1 is output, 2 is polarity, 3 is configuration. Its upper six bits are ignored.
- R5: Every later byte of a write transfer is acknowledged. It produces exactly one single-cycle `wr_stb`, with `wr_data` equal to the byte and `wr_ptr` equal to the current pointer.
- R6: The pointer keeps its value across Stop and Start and never advances after a data byte. Only a completed command byte changes it.
- R7: In a read transfer `rd_req` pulses for one cycle after the address acknowledge and after each data byte that the master acknowledges. The byte on `rd_data` for `rd_ptr` is sent MSB first, with each bit set up while SCL is low.
- R8: At the ninth clock of each byte of an addressed transfer, `ack_stb` pulses if SDA was low and `nack_stb` pulses if it was high. When the master leaves a read byte unacknowledged, the block keeps SDA released and requests no further data.
- R9: A repeated Start in any phase restarts address reception. This covers a write of the command byte, then a repeated Start, then a read of the pointed register.
- R10: A level change on SCL or SDA that lasts fewer than `STABLE` clock cycles is ignored. With the default of 5 cycles at the bench clock, a 2-cycle low pulse on SDA while SCL is high neither aborts the transfer nor corrupts the byte.
- R11: A Stop in any phase releases SDA and returns the block to idle. A data byte cut short by a Stop produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap | input | 2 | Low two address bits |
| sda_oe | output | 1 | High pulls SDA low |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_ptr | output | 2 | Register selected for the write |
| wr_data | output | 8 | Write data byte |
| rd_req | output | 1 | One-cycle read data request |
| rd_ptr | output | 2 | Register selected for the read |
| rd_data | input | 8 | Read data, sampled the cycle after `rd_req` |
| ack_stb | output | 1 | Ninth-bit acknowledge seen |
| nack_stb | output | 1 | Ninth-bit no-acknowledge seen |

## Verification
The bench aims first at pointer persistence. It reads again in a fresh transaction without a command byte, and it sends several data bytes in one transfer. A pointer that advanced, or that reset at Stop, would return a neighbouring register. It sends wrong straps and a command byte with its upper bits set. A design that decoded too many bits would acknowledge a foreign address or select the wrong register. It cuts a data byte short with a Stop, which must not produce a half-shifted write. It places a 2-cycle spike on SDA while SCL is high, which an unfiltered design would take as Start followed by Stop, losing the byte. Finally it ends a read with a no-acknowledge, after which a design that kept driving would block the Stop or fetch an extra byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_TACK,
    ST_TX,
    ST_RACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } rx_kind_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int STABLE = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl
);
  localparam int CW = $clog2(STABLE + 1);

  logic          sync1, sync2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      lvl   <= 1'b1;
      cnt   <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      if (sync2 == lvl) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE - 1)) begin
        lvl <= sync2;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: the filtered level only follows a synchronized value held for at least two cycles
  a_r10_filter_hold: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |-> ($past(sync2) == lvl && $past(sync2, 2) == lvl));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    start_ev = scl & scl_q & sda_q & ~sda;
    stop_ev  = scl & scl_q & ~sda_q & sda;
    rise_ev  = scl & ~scl_q;
    fall_ev  = ~scl & scl_q;
  end
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_tgt_pkg::*;
#(
  parameter int                 STABLE  = 5,
  parameter int                 STRAP_W = 2,
  parameter int                 PTR_W   = 2,
  parameter logic [6-STRAP_W:0] ADDR_HI = 5'b11100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_oe,
  output logic               wr_stb,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               rd_req,
  output logic [PTR_W-1:0]   rd_ptr,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               ack_stb,
  output logic               nack_stb
);
  localparam int NLINE = 2;
  localparam int BCW   = $clog2(BYTE_W);

  logic [NLINE-1:0] raw, flt;
  logic             scl_f, sda_f;
  logic             start_ev, stop_ev, rise_ev, fall_ev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_flt
    i2c_line_filter #(.STABLE(STABLE)) u_flt (
      .clk (clk),
      .rst (rst),
      .din (raw[g]),
      .lvl (flt[g])
    );
  end

  assign scl_f = flt[1];
  assign sda_f = flt[0];

  i2c_bus_events u_ev (
    .clk      (clk),
    .rst      (rst),
    .scl      (scl_f),
    .sda      (sda_f),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  tgt_state_t        st;
  rx_kind_t          kind;
  logic [BCW-1:0]    bitcnt;
  logic [BYTE_W-1:0] rxsh, txsh;
  logic              rw, phase, ld_pend;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] dev_addr;
  logic [BYTE_W-1:0] rx_byte;

  assign dev_addr = {ADDR_HI, strap};
  assign rx_byte  = {rxsh[BYTE_W-2:0], sda_f};
  assign wr_ptr   = ptr;
  assign rd_ptr   = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      rxsh     <= '0;
      txsh     <= '0;
      rw       <= 1'b0;
      phase    <= 1'b0;
      ld_pend  <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      ack_stb  <= 1'b0;
      nack_stb <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      rd_req   <= 1'b0;
      ack_stb  <= 1'b0;
      nack_stb <= 1'b0;
      ld_pend  <= rd_req;
      if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        st     <= ST_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        phase  <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (rise_ev) begin
              rxsh   <= rx_byte;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BCW'(BYTE_W - 1)) begin
                phase <= 1'b0;
                unique case (kind)
                  K_ADDR: begin
                    if (rx_byte[BYTE_W-1:1] == dev_addr) begin
                      rw     <= rx_byte[0];
                      rd_req <= rx_byte[0];
                      st     <= ST_TACK;
                    end else begin
                      st <= ST_IDLE;
                    end
                  end
                  K_CMD: begin
                    ptr <= rx_byte[PTR_W-1:0];
                    st  <= ST_TACK;
                  end
                  K_DATA: begin
                    wr_stb  <= 1'b1;
                    wr_data <= rx_byte;
                    st      <= ST_TACK;
                  end
                  default: st <= ST_IDLE;
                endcase
              end
            end
          end
          ST_TACK: begin
            if (fall_ev && !phase) begin
              sda_oe <= 1'b1;
            end else if (rise_ev) begin
              phase    <= 1'b1;
              ack_stb  <= ~sda_f;
              nack_stb <= sda_f;
            end else if (fall_ev && phase) begin
              bitcnt <= '0;
              phase  <= 1'b0;
              if (kind == K_ADDR && rw) begin
                st     <= ST_TX;
                sda_oe <= ~txsh[BYTE_W-1];
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
                kind   <= (kind == K_ADDR) ? K_CMD : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (rise_ev) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BCW'(BYTE_W - 1)) begin
                st    <= ST_RACK;
                phase <= 1'b0;
              end
            end else if (fall_ev) begin
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~txsh[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (fall_ev && !phase) begin
              sda_oe <= 1'b0;
            end else if (rise_ev) begin
              phase    <= 1'b1;
              ack_stb  <= ~sda_f;
              nack_stb <= sda_f;
              if (!sda_f) rd_req <= 1'b1;
              else        st     <= ST_IDLE;
            end else if (fall_ev && phase) begin
              st     <= ST_TX;
              bitcnt <= '0;
              phase  <= 1'b0;
              sda_oe <= ~txsh[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
      if (ld_pend) txsh <= rd_data;
    end
  end

  // R8: one ninth-bit outcome at a time
  a_r8_ack_excl: assert property (@(posedge clk) disable iff (rst)
    !(ack_stb && nack_stb));
  // R3: an idle engine never pulls the line
  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);
  // R11: a Stop always frees SDA
  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);
  // R6: the pointer moves only while a command byte is being received
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !(st == ST_RX && kind == K_CMD) |=> $stable(ptr));
  // R5: write strobe lasts one cycle
  a_r5_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  // R7: read request lasts one cycle
  a_r7_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
endmodule

// File: tb/i2c_ptr_target_bench.sv
module i2c_ptr_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 15;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe, wr_stb, rd_req, ack_stb, nack_stb;
  logic [1:0] wr_ptr, rd_ptr;
  logic [7:0] wr_data, rd_data;
  logic       sda_line;

  logic [7:0] bank [4];
  logic [7:0] exp_reg [4];
  logic [1:0] wlog_p [64];
  logic [7:0] wlog_d [64];
  int wcnt = 0, rcnt = 0, acks = 0, nacks = 0;
  logic [1:0] last_rptr = 2'd0;
  int checks = 0, errors = 0;
  bit glitch_en = 1'b0;
  bit done = 1'b0;
  logic [1:0] ptr_model = 2'd0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign rd_data  = bank[rd_ptr];

  i2c_ptr_target u_i2c_ptr_target (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .strap    (strap),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_ptr   (wr_ptr),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_ptr   (rd_ptr),
    .rd_data  (rd_data),
    .ack_stb  (ack_stb),
    .nack_stb (nack_stb)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        if (wcnt < 64) begin
          wlog_p[wcnt] = wr_ptr;
          wlog_d[wcnt] = wr_data;
        end
        bank[wr_ptr] = wr_data;
        wcnt++;
      end
      if (rd_req) begin
        rcnt++;
        last_rptr = rd_ptr;
      end
      if (ack_stb) acks++;
      if (nack_stb) nacks++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    wt(2 * Q); m_sda = 1'b0; wt(2 * Q); m_scl = 1'b0;
  endtask

  task automatic m_rstart();
    wt(Q); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(2 * Q); m_sda = 1'b0; wt(2 * Q); m_scl = 1'b0;
  endtask

  task automatic m_stop();
    wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(2 * Q); m_sda = 1'b1; wt(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    wt(Q); m_sda = b; wt(Q); m_scl = 1'b1;
    if (glitch_en && b) begin
      wt(10); m_sda = 1'b0; wt(2); m_sda = 1'b1; wt(2 * Q - 12);
    end else begin
      wt(2 * Q);
    end
    m_scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wt(Q); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); b = sda_line; wt(Q); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  function automatic logic [6:0] my_addr(input logic [1:0] s);
    return {5'b11100, s};
  endfunction

  task automatic write_xfer(input logic [7:0] cmd, input int n);
    bit ak;
    int w0;
    logic [7:0] d;
    logic [7:0] sent [8];
    w0 = wcnt;
    m_start();
    send_byte({my_addr(strap), 1'b0}, ak);
    chk(ak, "R2 write address ack", 32'(ak), 1);
    send_byte(cmd, ak);
    chk(ak, "R4 command ack", 32'(ak), 1);
    ptr_model = cmd[1:0];
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sent[i] = d;
      send_byte(d, ak);
      chk(ak, "R5 data ack", 32'(ak), 1);
      exp_reg[ptr_model] = d;
    end
    m_stop();
    wt(4);
    chk(wcnt == w0 + n, "R5 strobe count", 32'(wcnt - w0), 32'(n));
    for (int i = 0; i < n; i++) begin
      if (w0 + i < 64) begin
        chk(wlog_p[w0+i] == ptr_model, "R6 write pointer fixed", 32'(wlog_p[w0+i]), 32'(ptr_model));
        chk(wlog_d[w0+i] == sent[i], "R5 write data", 32'(wlog_d[w0+i]), 32'(sent[i]));
      end
    end
  endtask

  task automatic read_xfer(input bit with_cmd, input logic [7:0] cmd, input int n);
    bit ak;
    int r0, n0;
    logic [7:0] d;
    m_start();
    if (with_cmd) begin
      send_byte({my_addr(strap), 1'b0}, ak);
      chk(ak, "R2 address ack before command", 32'(ak), 1);
      send_byte(cmd, ak);
      chk(ak, "R4 command ack", 32'(ak), 1);
      ptr_model = cmd[1:0];
      m_rstart();
    end
    r0 = rcnt;
    n0 = nacks;
    send_byte({my_addr(strap), 1'b1}, ak);
    chk(ak, "R9 read address ack", 32'(ak), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d == exp_reg[ptr_model], "R7 read data", 32'(d), 32'(exp_reg[ptr_model]));
      chk(last_rptr == ptr_model, "R6 read pointer", 32'(last_rptr), 32'(ptr_model));
    end
    chk(sda_oe == 1'b0, "R8 released after no-ack", 32'(sda_oe), 0);
    m_stop();
    wt(4);
    chk(rcnt == r0 + n, "R7 request count", 32'(rcnt - r0), 32'(n));
    chk(nacks == n0 + 1, "R8 no-ack strobe", 32'(nacks - n0), 1);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", WD_LIMIT, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    int w0, a0, r0;
    void'($urandom(32'h1C2A));
    for (int i = 0; i < 4; i++) begin
      bank[i]    = 8'($urandom);
      exp_reg[i] = bank[i];
    end
    wt(5);
    rst = 1'b0;
    wt(3);
    chk(!sda_oe && !wr_stb && !rd_req && !ack_stb && !nack_stb, "R1 reset outputs",
        {27'd0, sda_oe, wr_stb, rd_req, ack_stb, nack_stb}, 0);
    chk(rd_ptr == 2'd0, "R1 reset pointer", 32'(rd_ptr), 0);

    // R1: read before any command fetches register 0
    read_xfer(1'b0, 8'h00, 1);

    // R3: wrong strap bits are not answered
    w0 = wcnt; a0 = acks; r0 = rcnt;
    m_start();
    send_byte({7'h71, 1'b0}, ak);
    chk(!ak, "R3 foreign address not acked", 32'(ak), 0);
    send_byte(8'h02, ak);
    send_byte(8'h5A, ak);
    chk(!ak, "R3 later bytes ignored", 32'(ak), 0);
    m_stop();
    wt(4);
    chk(wcnt == w0 && rcnt == r0 && acks == a0, "R3 no strobes", 32'(wcnt - w0 + rcnt - r0 + acks - a0), 0);
    chk(rd_ptr == ptr_model, "R3 pointer unchanged", 32'(rd_ptr), 32'(ptr_model));

    // R4: upper command bits ignored, R5 multi-byte write
    write_xfer(8'hFE, 3);
    // R9/R6/R7/R8: command, repeated start, 3-byte read
    read_xfer(1'b1, 8'h02, 3);
    // R6: pointer persists into a fresh transaction
    read_xfer(1'b0, 8'h00, 2);

    // R2: other strap value
    strap = 2'b01;
    write_xfer(8'h01, 1);
    read_xfer(1'b0, 8'h00, 1);

    // random traffic
    for (int it = 0; it < 5; it++) begin
      write_xfer({6'($urandom), 2'($urandom)}, 1 + int'($urandom % 3));
      read_xfer(it[0], {6'($urandom), ptr_model}, 1 + int'($urandom % 2));
    end

    // R10: spikes on SDA while SCL is high
    glitch_en = 1'b1;
    write_xfer(8'h03, 2);
    glitch_en = 1'b0;
    read_xfer(1'b0, 8'h00, 1);

    // R11: stop in the middle of a data byte
    w0 = wcnt;
    m_start();
    send_byte({my_addr(strap), 1'b0}, ak);
    send_byte(8'h00, ak);
    ptr_model = 2'd0;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    m_stop();
    wt(4);
    chk(wcnt == w0, "R11 no partial write", 32'(wcnt - w0), 0);
    chk(sda_oe == 1'b0, "R11 released at stop", 32'(sda_oe), 0);
    read_xfer(1'b0, 8'h00, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule